// File: doc/BRIEF.md
# Configuration Register Expansion Responder

This block sits on the user side of a PCIe endpoint and answers configuration-space accesses that the endpoint core passes out through its expansion port. Every configuration request appears on the port, including requests aimed at ranges the core serves itself. The block therefore decodes the full 12-bit byte address on every access. It serves only the two user windows and leaves every core-owned address untouched.

Addresses arrive as dword indices, which are byte address bits [11:2]. In the small window at byte 0x0C0 to 0x0FC, the block holds `LO_REGS` registers (16 by default), one per dword, starting at 0x0C0. In the large window at byte 0x200 to 0xFFC, it holds `HI_REGS` registers (8 by default), starting at 0x200. Writes are masked per byte. A read returns data one clock after its request, together with a one-cycle valid pulse, and the data then stays put until the next read.

The read path is driven by a three-state response machine:
- **RSP_EMPTY** is entered on reset. Data is zero and valid is low.
- **RSP_PULSE** is the cycle after a read request. Valid is high and the data has just been loaded.
- **RSP_HOLD** follows a pulse when no new read arrives. Valid is low and the data is frozen.

Transitions:
- **T_REQ**: any state goes to RSP_PULSE on a read request. This includes PULSE to PULSE for back-to-back reads.
- **T_IDLE**: RSP_PULSE goes to RSP_HOLD when no read is requested.
- **T_STAY**: RSP_EMPTY and RSP_HOLD stay where they are when no read is requested.
- **T_RST**: any state goes to RSP_EMPTY on reset.

Top module: `cfg_exp_responder`

## Requirements
- R1: Writes to core-owned byte addresses 0x000-0x0BC and 0x100-0x1FC (dword indices 0x000-0x02F and 0x040-0x07F) change no user register.
- R2: A read of a core-owned address gives a valid pulse one cycle later, with read data zero.
- R3: A write updates byte k (bits 8k+7:8k) of the addressed register only when byte enable bit k is 1. Bytes with a 0 enable keep their old value.
- R4: Read valid is high in exactly the cycle after a cycle with read enable high, and low in every other cycle.
- R5: Read data keeps its value from one read response until the next read response.
- R6: Addresses inside the user windows that hold no register read as zero, and writes to them are discarded.
- R7: If read and write enables are high in the same cycle, the write takes effect at that edge and the read returns the value held before it.
- R8: A synchronous active-high reset clears all user registers, the read data and read valid.
- R9: Register n of the small window sits at byte 0x0C0+4n (n < 16). Register n of the large window sits at byte 0x200+4n (n < 8). Reads return the last value written there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_addr | input | 10 | Dword address, byte address bits [11:2] |
| cfg_wr_en | input | 1 | Write request |
| cfg_wr_data | input | 32 | Write data |
| cfg_wr_be | input | 4 | Active-high byte enables for the write |
| cfg_rd_en | input | 1 | Read request |
| cfg_rd_data | output | 32 | Read data, held until the next read response |
| cfg_rd_valid | output | 1 | One-cycle pulse marking fresh read data |

## Verification
The assertions assume that the address is stable in any cycle where a request is raised, and that reset is applied for at least one clock before the port is used. The stimulus meets this by driving every input only at the falling edge. It holds reset for several cycles at the start and again near the end.

Random traffic draws addresses from five classes: the two core ranges, the small window, the implemented part of the large window, and the empty part of the large window. It mixes reads, writes and combined read-write cycles with random byte enables, so that every decode path meets every kind of access.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;

    localparam int ADDR_W = 10;
    localparam int DATA_W = 32;
    localparam int BYTES  = DATA_W / 8;

    // Dword indices of the address map (byte address >> 2)
    localparam logic [ADDR_W-1:0] WIN_LO_BASE = 10'h030; // byte 0x0C0
    localparam logic [ADDR_W-1:0] WIN_LO_END  = 10'h040; // byte 0x100, exclusive
    localparam logic [ADDR_W-1:0] WIN_HI_BASE = 10'h080; // byte 0x200

    typedef enum logic [1:0] {
        RGN_CORE   = 2'd0,
        RGN_WIN_LO = 2'd1,
        RGN_WIN_HI = 2'd2
    } region_e;

    typedef enum logic [1:0] {
        RSP_EMPTY = 2'd0,
        RSP_PULSE = 2'd1,
        RSP_HOLD  = 2'd2
    } rsp_state_e;

endpackage

// File: rtl/cfgx_decode.sv
module cfgx_decode
    import cfgx_pkg::*;
#(
    parameter int LO_REGS = 16,
    parameter int HI_REGS = 8,
    parameter int SLOT_W  = 5
) (
    input  logic [ADDR_W-1:0] addr,
    output region_e           region,
    output logic              hit,
    output logic [SLOT_W-1:0] slot
);

    localparam logic [ADDR_W-1:0] LO_CNT = ADDR_W'(LO_REGS);
    localparam logic [ADDR_W-1:0] HI_CNT = ADDR_W'(HI_REGS);

    logic [ADDR_W-1:0] off_lo;
    logic [ADDR_W-1:0] off_hi;

    assign off_lo = addr - WIN_LO_BASE;
    assign off_hi = addr - WIN_HI_BASE;

    always_comb begin
        region = RGN_CORE;
        hit    = 1'b0;
        slot   = '0;
        if (addr >= WIN_HI_BASE) begin
            region = RGN_WIN_HI;
            if (off_hi < HI_CNT) begin
                hit  = 1'b1;
                slot = SLOT_W'(LO_REGS) + SLOT_W'(off_hi);
            end
        end else if ((addr >= WIN_LO_BASE) && (addr < WIN_LO_END)) begin
            region = RGN_WIN_LO;
            if (off_lo < LO_CNT) begin
                hit  = 1'b1;
                slot = SLOT_W'(off_lo);
            end
        end
    end

endmodule

// File: rtl/cfgx_regbank.sv
module cfgx_regbank
    import cfgx_pkg::*;
#(
    parameter int NUM_REGS = 24,
    parameter int SLOT_W   = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              hit,
    input  logic [SLOT_W-1:0] slot,
    input  logic [BYTES-1:0]  wr_be,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_word
);

    logic [DATA_W-1:0] regs [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        logic sel;
        assign sel = wr_en && hit && (slot == SLOT_W'(g));
        for (genvar b = 0; b < BYTES; b++) begin : g_byte
            always_ff @(posedge clk) begin
                if (rst) begin
                    regs[g][b*8 +: 8] <= '0;
                end else if (sel && wr_be[b]) begin
                    regs[g][b*8 +: 8] <= wr_data[b*8 +: 8];
                end
            end
        end
    end

    // Read mux sees pre-write contents: read-before-write on a shared cycle
    always_comb begin
        rd_word = '0;
        if (hit) begin
            rd_word = regs[slot];
        end
    end

endmodule

// File: rtl/cfgx_rsp_fsm.sv
module cfgx_rsp_fsm
    import cfgx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] rd_word,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);

    rsp_state_e state_q;
    rsp_state_e state_d;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= RSP_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RSP_EMPTY: state_d = rd_en ? RSP_PULSE : RSP_EMPTY;
            RSP_PULSE: state_d = rd_en ? RSP_PULSE : RSP_HOLD;
            RSP_HOLD:  state_d = rd_en ? RSP_PULSE : RSP_HOLD;
            default:   state_d = RSP_EMPTY;
        endcase
    end

    // Output data register: loaded on every request, frozen otherwise
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
        end else if (state_d == RSP_PULSE) begin
            rd_data <= rd_word;
        end
    end

    assign rd_valid = (state_q == RSP_PULSE);

endmodule

// File: rtl/cfg_exp_responder.sv
module cfg_exp_responder
    import cfgx_pkg::*;
#(
    parameter int LO_REGS = 16,
    parameter int HI_REGS = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [9:0]        cfg_addr,
    input  logic              cfg_wr_en,
    input  logic [31:0]       cfg_wr_data,
    input  logic [3:0]        cfg_wr_be,
    input  logic              cfg_rd_en,
    output logic [31:0]       cfg_rd_data,
    output logic              cfg_rd_valid
);

    localparam int NUM_REGS = LO_REGS + HI_REGS;
    localparam int SLOT_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

    region_e           region;
    logic              hit;
    logic [SLOT_W-1:0] slot;
    logic [DATA_W-1:0] rd_word;

    cfgx_decode #(
        .LO_REGS (LO_REGS),
        .HI_REGS (HI_REGS),
        .SLOT_W  (SLOT_W)
    ) u_decode (
        .addr   (cfg_addr),
        .region (region),
        .hit    (hit),
        .slot   (slot)
    );

    cfgx_regbank #(
        .NUM_REGS (NUM_REGS),
        .SLOT_W   (SLOT_W)
    ) u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cfg_wr_en && (region != RGN_CORE)),
        .hit     (hit),
        .slot    (slot),
        .wr_be   (cfg_wr_be),
        .wr_data (cfg_wr_data),
        .rd_word (rd_word)
    );

    cfgx_rsp_fsm u_rsp (
        .clk      (clk),
        .rst      (rst),
        .rd_en    (cfg_rd_en),
        .rd_word  (rd_word),
        .rd_data  (cfg_rd_data),
        .rd_valid (cfg_rd_valid)
    );

endmodule

// File: rtl/cfg_exp_responder_chk.sv
module cfg_exp_responder_chk (
    input logic        clk,
    input logic        rst,
    input logic [9:0]  cfg_addr,
    input logic        cfg_rd_en,
    input logic [31:0] cfg_rd_data,
    input logic        cfg_rd_valid
);

    logic core_addr;
    assign core_addr = (cfg_addr < 10'h030) ||
                       ((cfg_addr >= 10'h040) && (cfg_addr < 10'h080));

    p_valid_after_req_r4: assert property (@(posedge clk) disable iff (rst)
        cfg_rd_en |=> cfg_rd_valid);

    p_no_spurious_valid_r4: assert property (@(posedge clk) disable iff (rst)
        !cfg_rd_en |=> !cfg_rd_valid);

    p_hold_data_r5: assert property (@(posedge clk) disable iff (rst)
        !cfg_rd_en |=> $stable(cfg_rd_data));

    p_core_read_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (cfg_rd_en && core_addr) |=> (cfg_rd_data == 32'h0));

    p_reset_clears_r8: assert property (@(posedge clk)
        rst |=> (!cfg_rd_valid && (cfg_rd_data == 32'h0)));

endmodule

bind cfg_exp_responder cfg_exp_responder_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .cfg_addr     (cfg_addr),
    .cfg_rd_en    (cfg_rd_en),
    .cfg_rd_data  (cfg_rd_data),
    .cfg_rd_valid (cfg_rd_valid)
);

// File: tb/cfg_exp_responder_tb.sv
module cfg_exp_responder_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NREG = 24;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [9:0]  cfg_addr = '0;
    logic        cfg_wr_en = 1'b0;
    logic [31:0] cfg_wr_data = '0;
    logic [3:0]  cfg_wr_be = '0;
    logic        cfg_rd_en = 1'b0;
    logic [31:0] cfg_rd_data;
    logic        cfg_rd_valid;

    int checks = 0;
    int errors = 0;
    logic [31:0] mdl [NREG];
    logic [31:0] exp_data = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_exp_responder u_dut (
        .clk          (clk),
        .rst          (rst),
        .cfg_addr     (cfg_addr),
        .cfg_wr_en    (cfg_wr_en),
        .cfg_wr_data  (cfg_wr_data),
        .cfg_wr_be    (cfg_wr_be),
        .cfg_rd_en    (cfg_rd_en),
        .cfg_rd_data  (cfg_rd_data),
        .cfg_rd_valid (cfg_rd_valid)
    );

    // Map per R9 / R6 / R1: -1 means no register behind the address
    function automatic int slot_of(logic [9:0] a);
        if (a >= 10'h030 && a < 10'h040) return int'(a - 10'h030);
        if (a >= 10'h080 && a < 10'h088) return 16 + int'(a - 10'h080);
        return -1;
    endfunction

    function automatic logic [31:0] mdl_read(logic [9:0] a);
        int s = slot_of(a);
        return (s < 0) ? 32'h0 : mdl[s];
    endfunction

    task automatic mdl_write(logic [9:0] a, logic [3:0] be, logic [31:0] d);
        int s = slot_of(a);
        if (s >= 0) begin
            for (int b = 0; b < 4; b++) begin
                if (be[b]) mdl[s][b*8 +: 8] = d[b*8 +: 8];
            end
        end
    endtask

    task automatic mdl_clear();
        for (int i = 0; i < NREG; i++) mdl[i] = '0;
        exp_data = '0;
    endtask

    task automatic chk(logic [31:0] act, logic [31:0] exp, string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // Drive one cycle at the falling edge, check the response at the next one
    task automatic step(bit rd, bit wr, logic [9:0] a, logic [3:0] be,
                        logic [31:0] d, string req);
        cfg_addr    = a;
        cfg_rd_en   = rd;
        cfg_wr_en   = wr;
        cfg_wr_be   = be;
        cfg_wr_data = d;
        if (rd) exp_data = mdl_read(a);     // R7: value before the write
        if (wr) mdl_write(a, be, d);
        @(posedge clk);
        @(negedge clk);
        cfg_rd_en = 1'b0;
        cfg_wr_en = 1'b0;
        chk({31'b0, cfg_rd_valid}, {31'b0, rd}, "R4");
        chk(cfg_rd_data, exp_data, req);
    endtask

    function automatic logic [9:0] rand_addr();
        int cls = $urandom_range(0, 4);
        case (cls)
            0:       return 10'($urandom_range(0, 10'h02F));
            1:       return 10'($urandom_range(10'h040, 10'h07F));
            2:       return 10'($urandom_range(10'h030, 10'h03F));
            3:       return 10'($urandom_range(10'h080, 10'h087));
            default: return 10'($urandom_range(10'h088, 10'h3FF));
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_c0fe));
        mdl_clear();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R8: reset state
        chk({31'b0, cfg_rd_valid}, 32'h0, "R8");
        chk(cfg_rd_data, 32'h0, "R8");

        // R9: fill all registers, read back each one
        for (int i = 0; i < 16; i++) step(0, 1, 10'(10'h030 + i), 4'hF, 32'hA000_0000 + i, "R9");
        for (int i = 0; i < 8; i++)  step(0, 1, 10'(10'h080 + i), 4'hF, 32'hB000_0000 + i, "R9");
        for (int i = 0; i < 16; i++) step(1, 0, 10'(10'h030 + i), 4'h0, 32'h0, "R9");
        for (int i = 0; i < 8; i++)  step(1, 0, 10'(10'h080 + i), 4'h0, 32'h0, "R9");

        // R1: core-owned writes at window edges, then confirm registers intact
        step(0, 1, 10'h02F, 4'hF, 32'hDEAD_BEEF, "R1");
        step(0, 1, 10'h040, 4'hF, 32'hDEAD_BEEF, "R1");
        step(0, 1, 10'h07F, 4'hF, 32'hDEAD_BEEF, "R1");
        step(0, 1, 10'h000, 4'hF, 32'hDEAD_BEEF, "R1");
        step(1, 0, 10'h030, 4'h0, 32'h0, "R1");
        step(1, 0, 10'h03F, 4'h0, 32'h0, "R1");
        step(1, 0, 10'h080, 4'h0, 32'h0, "R1");

        // R2: core reads return zero with valid
        step(1, 0, 10'h02F, 4'h0, 32'h0, "R2");
        step(1, 0, 10'h040, 4'h0, 32'h0, "R2");

        // R3: partial byte enables
        step(0, 1, 10'h031, 4'b0101, 32'h1122_3344, "R3");
        step(1, 0, 10'h031, 4'h0, 32'h0, "R3");
        step(0, 1, 10'h081, 4'b1000, 32'h5500_0000, "R3");
        step(1, 0, 10'h081, 4'h0, 32'h0, "R3");

        // R6: empty window address
        step(0, 1, 10'h088, 4'hF, 32'hCAFE_F00D, "R6");
        step(1, 0, 10'h088, 4'h0, 32'h0, "R6");
        step(1, 0, 10'h3FF, 4'h0, 32'h0, "R6");

        // R7: read and write in the same cycle, then the new value
        step(1, 1, 10'h035, 4'hF, 32'h7777_7777, "R7");
        step(1, 0, 10'h035, 4'h0, 32'h0, "R7");

        // R5: data holds over idle cycles and over writes
        step(1, 0, 10'h084, 4'h0, 32'h0, "R5");
        step(0, 0, 10'h000, 4'h0, 32'h0, "R5");
        step(0, 1, 10'h084, 4'hF, 32'h0BAD_0BAD, "R5");
        step(0, 0, 10'h030, 4'h0, 32'h0, "R5");

        // Random traffic
        for (int n = 0; n < 3000; n++) begin
            step(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), rand_addr(),
                 4'($urandom), $urandom, "R5");
        end

        // R8: reset after traffic clears registers
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        mdl_clear();
        chk({31'b0, cfg_rd_valid}, 32'h0, "R8");
        chk(cfg_rd_data, 32'h0, "R8");
        step(1, 0, 10'h035, 4'h0, 32'h0, "R8");
        step(1, 0, 10'h084, 4'h0, 32'h0, "R8");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule